// File: doc/BRIEF.md
# D-PHY Clock Lane Sequencer

This block is the digital controller for the clock lane of a D-PHY transmitter. On a high-speed request it takes the lane out of the low-power stop state through a request, prepare and zero phase. It then starts the continuous high-speed clock. After a programmable pre interval it releases the data lanes. When the request is withdrawn and the data lanes report idle, the clock keeps running for a post interval. The lane then drives a trail interval and returns to stop. Every interval is a byte-clock count that software rounds up from the required time. The post count already includes the data lane trail time.

The low-power line levels, a high-speed driver enable, a low-power driver enable and a clock-toggle qualifier go to the analog lane, which is outside this block. Software can force either enable through a select/value pair. A power-down input silences both enables whatever the overrides say and returns the sequencer to stop. An ultra-low-power entry and exit is also provided. A four-bit status word reports the analog bias ready flag, stop, ultra-low-power and clock-active.

Top module: `dphy_clk_lane_seq`

## Requirements
- R1: After reset the lane is in stop: lp_dp_o=1, lp_dn_o=1, lp_en_o=1, hs_en_o=0, hs_toggle_o=0, data_go_o=0, and status_o[2] (stop) is 1.
- R2: A high-speed request seen in stop starts the start sequence on the next cycle. The lines are driven to LP-01 (dp=0, dn=1) for t_lpx cycles, then to LP-00 for t_prep cycles. Then hs_en_o=1 with hs_toggle_o=0 for t_zero cycles, and then hs_toggle_o=1.
- R3: data_go_o rises exactly t_pre cycles after hs_toggle_o first rises. It is high only while the clock toggles.
- R4: In the active state, a withdrawn request with data_idle_i=1 drops data_go_o on the next cycle. hs_toggle_o then stays high for t_post cycles. hs_en_o stays high with hs_toggle_o=0 for t_trail cycles, and the lane then returns to stop.
- R5: While data_idle_i=0 the active state is held, and data_go_o stays high even with the request withdrawn.
- R6: A request raised during the post or trail phase takes no effect until stop is reached. From stop the start sequence then begins on the following cycle.
- R7: A count of zero lasts one cycle, exactly like a count of one.
- R8: When hs_ovr_sel_i (or lp_ovr_sel_i) is 1, hs_en_o (or lp_en_o) equals hs_ovr_val_i (or lp_ovr_val_i). When the select is 0, the enable follows the sequencer.
- R9: While pwr_down_i=1, hs_en_o, lp_en_o and data_go_o are 0 regardless of overrides. The sequencer is in stop from the next cycle.
- R10: A low-power-state request (ulps_req_i) in stop, with no high-speed request, drives LP-10 (dp=1, dn=0) for t_lpx cycles. It then drives LP-00 with status_o[1]=1 until the request drops. After that it drives LP-10 for t_lpx cycles and returns to stop. A high-speed request has priority in stop.
- R11: status_o = {mbias_ready_i, stop, ulps, clock active}. Clock active (bit 0) equals hs_toggle_o, and at most one of bits 2..0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_req_i | input | 1 | High-speed clock request |
| data_idle_i | input | 1 | Data lanes have left high-speed |
| ulps_req_i | input | 1 | Ultra-low-power request |
| pwr_down_i | input | 1 | PHY power-down |
| mbias_ready_i | input | 1 | Analog bias ready flag |
| t_lpx_i | input | CNT_W | Request / mark interval count |
| t_prep_i | input | CNT_W | Prepare count |
| t_zero_i | input | CNT_W | HS-zero count |
| t_pre_i | input | CNT_W | Clock-before-data count |
| t_post_i | input | CNT_W | Clock-after-data count (includes data trail) |
| t_trail_i | input | CNT_W | Clock trail count |
| hs_ovr_sel_i | input | 1 | Select register value for hs_en_o |
| hs_ovr_val_i | input | 1 | Register value for hs_en_o |
| lp_ovr_sel_i | input | 1 | Select register value for lp_en_o |
| lp_ovr_val_i | input | 1 | Register value for lp_en_o |
| hs_en_o | output | 1 | High-speed driver enable |
| lp_en_o | output | 1 | Low-power driver enable |
| hs_toggle_o | output | 1 | Clock toggling (0 with hs_en_o = HS-0) |
| lp_dp_o | output | 1 | Low-power level, positive line |
| lp_dn_o | output | 1 | Low-power level, negative line |
| data_go_o | output | 1 | Data lanes released for high-speed |
| status_o | output | 4 | {bias ready, stop, ulps, clock active} |

## Verification
The main collision is between the stop condition and a fresh request. A request that rises inside the post window meets a running stop sequence. The bench drives it two cycles into post and expects the post, trail and one stop cycle to run unchanged before the request phase starts. A second collision is a power-down that lands in the same cycle as an active clock with overrides forcing both enables high. Both enables and data release must read 0 in that cycle, and the lane must report stop on the next. A cycle model in the bench judges every cycle, and edge-to-edge counters measure the pre, post and trail widths.

// File: rtl/dphy_clk_pkg.sv
`timescale 1ns/1ps
package dphy_clk_pkg;

  typedef enum logic [3:0] {
    CL_STOP, CL_RQST, CL_PREP, CL_ZERO, CL_PRE, CL_ACTIVE,
    CL_POST, CL_TRAIL, CL_UENT, CL_ULPS, CL_UEXIT
  } cl_state_e;

  localparam int unsigned NUM_TIM = 6;
  localparam int unsigned TIM_W   = $clog2(NUM_TIM);

  localparam logic [TIM_W-1:0] TIM_LPX   = TIM_W'(0);
  localparam logic [TIM_W-1:0] TIM_PREP  = TIM_W'(1);
  localparam logic [TIM_W-1:0] TIM_ZERO  = TIM_W'(2);
  localparam logic [TIM_W-1:0] TIM_PRE   = TIM_W'(3);
  localparam logic [TIM_W-1:0] TIM_POST  = TIM_W'(4);
  localparam logic [TIM_W-1:0] TIM_TRAIL = TIM_W'(5);

  typedef struct packed {
    logic lp_dp;
    logic lp_dn;
    logic lp_en;
    logic hs_en;
    logic hs_tog;
    logic go;
  } cl_drv_t;

  function automatic logic is_timed(cl_state_e s);
    case (s)
      CL_RQST, CL_PREP, CL_ZERO, CL_PRE, CL_POST, CL_TRAIL,
      CL_UENT, CL_UEXIT: is_timed = 1'b1;
      default:           is_timed = 1'b0;
    endcase
  endfunction

  function automatic logic [TIM_W-1:0] tim_of(cl_state_e s);
    case (s)
      CL_PREP:  tim_of = TIM_PREP;
      CL_ZERO:  tim_of = TIM_ZERO;
      CL_PRE:   tim_of = TIM_PRE;
      CL_POST:  tim_of = TIM_POST;
      CL_TRAIL: tim_of = TIM_TRAIL;
      default:  tim_of = TIM_LPX;
    endcase
  endfunction

  function automatic cl_drv_t drv_of(cl_state_e s);
    cl_drv_t d;
    d = '0;
    case (s)
      CL_STOP:   begin d.lp_dp = 1'b1; d.lp_dn = 1'b1; d.lp_en = 1'b1; end
      CL_RQST:   begin d.lp_dn = 1'b1; d.lp_en = 1'b1; end
      CL_PREP:   d.lp_en = 1'b1;
      CL_ZERO:   d.hs_en = 1'b1;
      CL_PRE:    begin d.hs_en = 1'b1; d.hs_tog = 1'b1; end
      CL_ACTIVE: begin d.hs_en = 1'b1; d.hs_tog = 1'b1; d.go = 1'b1; end
      CL_POST:   begin d.hs_en = 1'b1; d.hs_tog = 1'b1; end
      CL_TRAIL:  d.hs_en = 1'b1;
      CL_UENT,
      CL_UEXIT:  begin d.lp_dp = 1'b1; d.lp_en = 1'b1; end
      CL_ULPS:   d.lp_en = 1'b1;
      default:   d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/clk_seq_timer.sv
`timescale 1ns/1ps
module clk_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(1);
    end else if (load_i) begin
      // zero is treated as a single cycle
      cnt_q <= (val_i == '0) ? CNT_W'(1) : val_i;
    end else if (cnt_q > CNT_W'(1)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/clk_seq_fsm.sv
`timescale 1ns/1ps
module clk_seq_fsm
  import dphy_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_req_i,
  input  logic             data_idle_i,
  input  logic             ulps_req_i,
  input  logic             pwr_down_i,
  input  logic             tim_last_i,
  output cl_state_e        state_o,
  output logic             load_o,
  output logic [TIM_W-1:0] load_sel_o
);
  cl_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    if (pwr_down_i) begin
      state_n = CL_STOP;
    end else begin
      case (state_q)
        CL_STOP: begin
          if (hs_req_i)        state_n = CL_RQST;
          else if (ulps_req_i) state_n = CL_UENT;
        end
        CL_RQST:   if (tim_last_i) state_n = CL_PREP;
        CL_PREP:   if (tim_last_i) state_n = CL_ZERO;
        CL_ZERO:   if (tim_last_i) state_n = CL_PRE;
        CL_PRE:    if (tim_last_i) state_n = CL_ACTIVE;
        CL_ACTIVE: if (!hs_req_i && data_idle_i) state_n = CL_POST;
        CL_POST:   if (tim_last_i) state_n = CL_TRAIL;
        CL_TRAIL:  if (tim_last_i) state_n = CL_STOP;
        CL_UENT:   if (tim_last_i) state_n = CL_ULPS;
        CL_ULPS:   if (!ulps_req_i) state_n = CL_UEXIT;
        CL_UEXIT:  if (tim_last_i) state_n = CL_STOP;
        default:   state_n = CL_STOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CL_STOP;
    else         state_q <= state_n;
  end

  assign load_o     = (state_n != state_q) && is_timed(state_n);
  assign load_sel_o = tim_of(state_n);
  assign state_o    = state_q;
endmodule

// File: rtl/lane_en_ovr.sv
`timescale 1ns/1ps
module lane_en_ovr #(
  parameter int unsigned NUM_EN = 2
) (
  input  logic [NUM_EN-1:0] fsm_en_i,
  input  logic [NUM_EN-1:0] sel_i,
  input  logic [NUM_EN-1:0] val_i,
  input  logic              kill_i,
  output logic [NUM_EN-1:0] en_o
);
  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    assign en_o[g] = kill_i ? 1'b0 : (sel_i[g] ? val_i[g] : fsm_en_i[g]);
  end
endmodule

// File: rtl/dphy_clk_lane_seq.sv
`timescale 1ns/1ps
module dphy_clk_lane_seq
  import dphy_clk_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_req_i,
  input  logic             data_idle_i,
  input  logic             ulps_req_i,
  input  logic             pwr_down_i,
  input  logic             mbias_ready_i,
  input  logic [CNT_W-1:0] t_lpx_i,
  input  logic [CNT_W-1:0] t_prep_i,
  input  logic [CNT_W-1:0] t_zero_i,
  input  logic [CNT_W-1:0] t_pre_i,
  input  logic [CNT_W-1:0] t_post_i,
  input  logic [CNT_W-1:0] t_trail_i,
  input  logic             hs_ovr_sel_i,
  input  logic             hs_ovr_val_i,
  input  logic             lp_ovr_sel_i,
  input  logic             lp_ovr_val_i,
  output logic             hs_en_o,
  output logic             lp_en_o,
  output logic             hs_toggle_o,
  output logic             lp_dp_o,
  output logic             lp_dn_o,
  output logic             data_go_o,
  output logic [3:0]       status_o
);
  localparam int unsigned NUM_EN = 2;
  localparam int unsigned EN_HS  = 0;
  localparam int unsigned EN_LP  = 1;

  cl_state_e        state;
  cl_drv_t          drv;
  logic             tim_load, tim_last;
  logic [TIM_W-1:0] tim_sel;
  logic [CNT_W-1:0] tim_val;
  logic [CNT_W-1:0] dur [NUM_TIM];
  logic [NUM_EN-1:0] fsm_en, ovr_sel, ovr_val, en;

  assign dur[TIM_LPX]   = t_lpx_i;
  assign dur[TIM_PREP]  = t_prep_i;
  assign dur[TIM_ZERO]  = t_zero_i;
  assign dur[TIM_PRE]   = t_pre_i;
  assign dur[TIM_POST]  = t_post_i;
  assign dur[TIM_TRAIL] = t_trail_i;
  assign tim_val        = dur[tim_sel];

  clk_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hs_req_i    (hs_req_i),
    .data_idle_i (data_idle_i),
    .ulps_req_i  (ulps_req_i),
    .pwr_down_i  (pwr_down_i),
    .tim_last_i  (tim_last),
    .state_o     (state),
    .load_o      (tim_load),
    .load_sel_o  (tim_sel)
  );

  clk_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tim_load),
    .val_i  (tim_val),
    .last_o (tim_last)
  );

  assign drv = drv_of(state);

  assign fsm_en[EN_HS]  = drv.hs_en;
  assign fsm_en[EN_LP]  = drv.lp_en;
  assign ovr_sel[EN_HS] = hs_ovr_sel_i;
  assign ovr_sel[EN_LP] = lp_ovr_sel_i;
  assign ovr_val[EN_HS] = hs_ovr_val_i;
  assign ovr_val[EN_LP] = lp_ovr_val_i;

  lane_en_ovr #(.NUM_EN(NUM_EN)) u_ovr (
    .fsm_en_i (fsm_en),
    .sel_i    (ovr_sel),
    .val_i    (ovr_val),
    .kill_i   (pwr_down_i),
    .en_o     (en)
  );

  assign hs_en_o     = en[EN_HS];
  assign lp_en_o     = en[EN_LP];
  assign hs_toggle_o = drv.hs_tog;
  assign lp_dp_o     = drv.lp_dp;
  assign lp_dn_o     = drv.lp_dn;
  assign data_go_o   = drv.go & ~pwr_down_i;
  assign status_o    = {mbias_ready_i, state == CL_STOP, state == CL_ULPS, drv.hs_tog};
endmodule

// File: rtl/dphy_clk_lane_seq_chk.sv
`timescale 1ns/1ps
module dphy_clk_lane_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hs_req_i,
  input logic       data_idle_i,
  input logic       ulps_req_i,
  input logic       pwr_down_i,
  input logic       hs_ovr_sel_i,
  input logic       hs_ovr_val_i,
  input logic       hs_en_o,
  input logic       lp_en_o,
  input logic       hs_toggle_o,
  input logic       lp_dp_o,
  input logic       lp_dn_o,
  input logic       data_go_o,
  input logic [3:0] status_o
);
  a_r3_go_needs_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_go_o |-> hs_toggle_o);

  a_r9_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> (!hs_en_o && !lp_en_o && !data_go_o));

  a_r9_pd_to_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> status_o[2]);

  a_r4_go_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_go_o && !hs_req_i && data_idle_i) |=> !data_go_o);

  a_r5_go_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_go_o && !data_idle_i && !pwr_down_i) |=> data_go_o);

  a_r2_request_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] && hs_req_i && !pwr_down_i) |=> (!lp_dp_o && lp_dn_o));

  a_r10_ulps_exit_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !ulps_req_i && !pwr_down_i) |=> (lp_dp_o && !lp_dn_o));

  a_r11_one_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[2:0]));

  a_r8_hs_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_down_i && hs_ovr_sel_i) |-> (hs_en_o == hs_ovr_val_i));
endmodule

bind dphy_clk_lane_seq dphy_clk_lane_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hs_req_i     (hs_req_i),
  .data_idle_i  (data_idle_i),
  .ulps_req_i   (ulps_req_i),
  .pwr_down_i   (pwr_down_i),
  .hs_ovr_sel_i (hs_ovr_sel_i),
  .hs_ovr_val_i (hs_ovr_val_i),
  .hs_en_o      (hs_en_o),
  .lp_en_o      (lp_en_o),
  .hs_toggle_o  (hs_toggle_o),
  .lp_dp_o      (lp_dp_o),
  .lp_dn_o      (lp_dn_o),
  .data_go_o    (data_go_o),
  .status_o     (status_o)
);

// File: tb/dphy_clk_lane_seq_tb.sv
`timescale 1ns/1ps
module dphy_clk_lane_seq_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hs_req_i = 0, data_idle_i = 1, ulps_req_i = 0, pwr_down_i = 0, mbias_ready_i = 1;
  logic [7:0] t_lpx_i = 2, t_prep_i = 3, t_zero_i = 4, t_pre_i = 5, t_post_i = 3, t_trail_i = 2;
  logic hs_ovr_sel_i = 0, hs_ovr_val_i = 0, lp_ovr_sel_i = 0, lp_ovr_val_i = 0;
  logic hs_en_o, lp_en_o, hs_toggle_o, lp_dp_o, lp_dn_o, data_go_o;
  logic [3:0] status_o;

  always #4 clk_i = ~clk_i;

  dphy_clk_lane_seq u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: phases
  localparam int P_STOP = 0, P_RQST = 1, P_PREP = 2, P_ZERO = 3, P_PRE = 4, P_ACT = 5,
                 P_POST = 6, P_TRAIL = 7, P_UENT = 8, P_ULPS = 9, P_UEXIT = 10;
  int m_ph = P_STOP;
  int m_rem = 1;

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic enter(input int ph, input int cnt);
    m_ph = ph;
    m_rem = atleast1(cnt);
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = P_STOP; m_rem = 1;
    end else if (pwr_down_i) begin
      m_ph = P_STOP;
    end else if (m_ph == P_STOP) begin
      if (hs_req_i) enter(P_RQST, int'(t_lpx_i));
      else if (ulps_req_i) enter(P_UENT, int'(t_lpx_i));
    end else if (m_ph == P_ACT) begin
      if (!hs_req_i && data_idle_i) enter(P_POST, int'(t_post_i));
    end else if (m_ph == P_ULPS) begin
      if (!ulps_req_i) enter(P_UEXIT, int'(t_lpx_i));
    end else if (m_rem > 1) begin
      m_rem--;
    end else begin
      case (m_ph)
        P_RQST:  enter(P_PREP, int'(t_prep_i));
        P_PREP:  enter(P_ZERO, int'(t_zero_i));
        P_ZERO:  enter(P_PRE, int'(t_pre_i));
        P_PRE:   enter(P_ACT, 1);
        P_POST:  enter(P_TRAIL, int'(t_trail_i));
        P_UENT:  enter(P_ULPS, 1);
        default: enter(P_STOP, 1);
      endcase
    end
  end

  // {dp, dn, lp_en, hs_en, toggle, go}
  function automatic logic [5:0] exp_drv(input int ph);
    case (ph)
      P_STOP:  return 6'b111000;
      P_RQST:  return 6'b011000;
      P_PREP:  return 6'b001000;
      P_ZERO:  return 6'b000100;
      P_PRE:   return 6'b000110;
      P_ACT:   return 6'b000111;
      P_POST:  return 6'b000110;
      P_TRAIL: return 6'b000100;
      P_UENT, P_UEXIT: return 6'b101000;
      default: return 6'b001000;
    endcase
  endfunction

  // per-cycle comparison plus edge-to-edge width measurement
  bit mon_en = 0;
  int cyc = 0, t_tog_rise = 0, t_go_fall = 0, t_tog_fall = 0;
  logic p_tog = 0, p_go = 0, p_hs = 0;

  always @(negedge clk_i) begin
    logic [5:0] d;
    logic e_hs, e_lp, e_go;
    logic [3:0] e_st;
    cyc++;
    if (rst_ni) begin
      d = exp_drv(m_ph);
      e_lp = pwr_down_i ? 1'b0 : (lp_ovr_sel_i ? lp_ovr_val_i : d[3]);
      e_hs = pwr_down_i ? 1'b0 : (hs_ovr_sel_i ? hs_ovr_val_i : d[2]);
      e_go = d[0] & ~pwr_down_i;
      e_st = {mbias_ready_i, m_ph == P_STOP, m_ph == P_ULPS, d[1]};
      chk({lp_dp_o, lp_dn_o} == d[5:4], "R2/R10 lp lines", {lp_dp_o, lp_dn_o}, d[5:4]);
      chk(hs_toggle_o == d[1], "R2/R4 toggle", hs_toggle_o, d[1]);
      chk(data_go_o == e_go, "R3/R5 data_go", data_go_o, e_go);
      chk(hs_en_o == e_hs, "R8/R9 hs_en", hs_en_o, e_hs);
      chk(lp_en_o == e_lp, "R8/R9 lp_en", lp_en_o, e_lp);
      chk(status_o == e_st, "R11 status", status_o, e_st);
      if (mon_en) begin
        if (hs_toggle_o && !p_tog) t_tog_rise = cyc;
        if (data_go_o && !p_go)
          chk(cyc - t_tog_rise == atleast1(int'(t_pre_i)), "R3 pre width",
              cyc - t_tog_rise, atleast1(int'(t_pre_i)));
        if (!data_go_o && p_go) t_go_fall = cyc;
        if (!hs_toggle_o && p_tog) begin
          t_tog_fall = cyc;
          chk(cyc - t_go_fall == atleast1(int'(t_post_i)), "R4 post width",
              cyc - t_go_fall, atleast1(int'(t_post_i)));
        end
        if (!hs_en_o && p_hs)
          chk(cyc - t_tog_fall == atleast1(int'(t_trail_i)), "R4 trail width",
              cyc - t_tog_fall, atleast1(int'(t_trail_i)));
      end
      p_tog = hs_toggle_o; p_go = data_go_o; p_hs = hs_en_o;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic set_tim(input int lpx, prep, zero, pre, post, trail);
    t_lpx_i = 8'(lpx); t_prep_i = 8'(prep); t_zero_i = 8'(zero);
    t_pre_i = 8'(pre); t_post_i = 8'(post); t_trail_i = 8'(trail);
  endtask

  task automatic burst(input int on_cyc);
    hs_req_i = 1; data_idle_i = 1;
    step(on_cyc);
    hs_req_i = 0;
    step(40);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1;
    step(1);
    @(negedge clk_i);
    // R1: reset state
    chk(lp_dp_o && lp_dn_o && lp_en_o && !hs_en_o && !data_go_o && status_o[2],
        "R1 reset stop", {lp_dp_o, lp_dn_o, lp_en_o, hs_en_o, data_go_o}, 5'b11100);
    mon_en = 1;
    step(1);

    // R2 R3 R4: full cycle, timing set A
    burst(40);

    // R5: request withdrawn but data busy
    hs_req_i = 1; data_idle_i = 0;
    step(30);
    hs_req_i = 0;
    step(10);
    @(negedge clk_i);
    chk(data_go_o == 1'b1, "R5 held while busy", data_go_o, 1);
    data_idle_i = 1;
    step(30);

    // R6: request raised two cycles into post
    hs_req_i = 1;
    step(30);
    hs_req_i = 0;
    step(2);
    hs_req_i = 1;
    step(2);
    @(negedge clk_i);
    chk(hs_en_o == 1'b1 && data_go_o == 1'b0, "R6 stop not aborted", {hs_en_o, data_go_o}, 2'b10);
    step(40);
    @(negedge clk_i);
    chk(data_go_o == 1'b1, "R6 restarted", data_go_o, 1);
    hs_req_i = 0;
    step(30);

    // R7: all counts zero
    set_tim(0, 0, 0, 0, 0, 0);
    burst(20);

    // timing set B
    set_tim(7, 1, 9, 12, 6, 4);
    burst(60);

    // R8: overrides in stop
    mon_en = 0;
    hs_ovr_sel_i = 1; hs_ovr_val_i = 1; lp_ovr_sel_i = 1; lp_ovr_val_i = 0;
    step(2);
    @(negedge clk_i);
    chk(hs_en_o == 1'b1 && lp_en_o == 1'b0, "R8 override", {hs_en_o, lp_en_o}, 2'b10);
    hs_ovr_sel_i = 0; lp_ovr_sel_i = 0;
    step(2);
    @(negedge clk_i);
    chk(hs_en_o == 1'b0 && lp_en_o == 1'b1, "R8 fsm drive", {hs_en_o, lp_en_o}, 2'b01);

    // R9: power-down while active with overrides forcing 1
    set_tim(2, 3, 4, 5, 3, 2);
    hs_req_i = 1;
    step(40);
    hs_ovr_sel_i = 1; hs_ovr_val_i = 1; lp_ovr_sel_i = 1; lp_ovr_val_i = 1;
    pwr_down_i = 1;
    @(negedge clk_i);
    chk(!hs_en_o && !lp_en_o && !data_go_o, "R9 pd silences", {hs_en_o, lp_en_o, data_go_o}, 0);
    step(1);
    @(negedge clk_i);
    chk(status_o[2] == 1'b1, "R9 pd stop", status_o, 4'b1100);
    step(3);
    pwr_down_i = 0; hs_ovr_sel_i = 0; lp_ovr_sel_i = 0;
    step(40);
    hs_req_i = 0;
    step(30);

    // R10: low-power state entry/exit
    mon_en = 1;
    mbias_ready_i = 0;
    ulps_req_i = 1;
    step(10);
    @(negedge clk_i);
    chk(status_o[1] == 1'b1, "R10 ulps entered", status_o, 4'b0010);
    ulps_req_i = 0;
    step(10);
    @(negedge clk_i);
    chk(status_o[2] == 1'b1, "R10 ulps left", status_o, 4'b0100);
    mbias_ready_i = 1;
    // R10: high-speed priority in stop
    ulps_req_i = 1; hs_req_i = 1;
    step(1);
    @(negedge clk_i);
    chk(!lp_dp_o && lp_dn_o, "R10 hs priority", {lp_dp_o, lp_dn_o}, 2'b01);
    ulps_req_i = 0;
    step(30);
    hs_req_i = 0;
    step(30);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule